// File: doc/BRIEF.md
# Segment Translation and Protection Unit

The unit turns a logical address, made of a segment number and an offset within that segment, into a physical address. It uses a small table of segment descriptors. Each descriptor holds a physical base, a length limit, a present flag and three access-right bits. A segment-count register gives how many descriptors are in use.

Every lookup passes through four legality checks in a fixed order. The segment number is checked against the count. The descriptor must be marked present. The offset must lie below the limit. The requested access kind must be allowed. A lookup that passes all four returns the base plus the offset one clock later. A lookup that fails any check returns a trap with a code that names the highest-priority failure.

The descriptors and the count are written through a simple write port. A write takes effect for lookups in later cycles.

Top module: `seg_xlate_unit`

## Requirements
- R1: A response (`rsp_valid` high) appears exactly one clock after each cycle with `req_valid` high, and in no other cycle.
- R2: A lookup whose segment number is greater than or equal to the segment-count register traps with code 1.
- R3: A lookup of a segment that is in range but whose descriptor present flag is 0 traps with code 2.
- R4: A lookup whose offset is greater than or equal to the descriptor limit traps with code 3. An offset equal to the limit traps.
- R5: A lookup whose access kind is not allowed traps with code 4. The access kind encoding is 00 read, 01 write, 10 execute. Rights bit 0 allows read, bit 1 allows write and bit 2 allows execute. Access kind 11 is never allowed.
- R6: A legal lookup returns `rsp_trap`=0, code 0 and a physical address equal to base plus zero-extended offset, taken modulo 2^PA_W.
- R7: When several failures apply at once, the reported code is the first failing check in this order: range (1), present (2), limit (3), rights (4).
- R8: A descriptor or count write in the same cycle as a lookup does not affect that lookup. It does affect lookups in later cycles.
- R9: After reset every descriptor is not present, the count is 0 and no response is pending, so any lookup traps with code 1.
- R10: A trapping response carries a physical address of 0, and `rsp_trap` is high exactly when the code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_idx | input | SEG_W | Descriptor index to write |
| tbl_base | input | PA_W | Physical base to store |
| tbl_limit | input | OFF_W | Segment length to store |
| tbl_present | input | 1 | Present flag to store |
| tbl_rights | input | 3 | Access rights to store: bit0 read, bit1 write, bit2 execute |
| cnt_we | input | 1 | Segment-count write strobe |
| cnt_val | input | CNT_W | New segment count |
| req_valid | input | 1 | Lookup request |
| req_seg | input | SEG_W | Logical segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| rsp_valid | output | 1 | Response valid |
| rsp_trap | output | 1 | Lookup was illegal |
| rsp_code | output | 3 | 0 legal, 1 range, 2 not present, 3 limit, 4 rights |
| rsp_paddr | output | PA_W | Translated physical address, 0 on a trap |

## Verification
The hardest case to reach is a lookup in which several checks fail together. The bench must then show that the code follows the priority order and is not simply the last failure found. The stimulus builds descriptors that fail on purpose: one not present but also too short and without rights, and one with a maximal limit and read-only rights. The bench then probes them with offsets and access kinds that break two or three rules at once. A second hard case is a descriptor write that lands in the same cycle as a lookup of that descriptor. The driver issues both in one cycle and the lookup of the same segment again in the next cycle, so the old and new contents are both observed.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    TC_NONE    = 3'd0,
    TC_RANGE   = 3'd1,
    TC_ABSENT  = 3'd2,
    TC_LIMIT   = 3'd3,
    TC_RIGHTS  = 3'd4
  } trap_code_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int RIGHT_RD = 0;
  localparam int RIGHT_WR = 1;
  localparam int RIGHT_EX = 2;
  localparam int RIGHTS_W = 3;

  // Rights check: access kind against a three-bit rights field.
  function automatic logic rights_allow(input logic [RIGHTS_W-1:0] rights,
                                        input logic [1:0] acc);
    case (acc)
      ACC_READ:  return rights[RIGHT_RD];
      ACC_WRITE: return rights[RIGHT_WR];
      ACC_EXEC:  return rights[RIGHT_EX];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEG_W-1:0]    wr_idx,
  input  logic [PA_W-1:0]     wr_base,
  input  logic [OFF_W-1:0]    wr_limit,
  input  logic                wr_present,
  input  logic [RIGHTS_W-1:0] wr_rights,
  input  logic [SEG_W-1:0]    rd_idx,
  output logic [PA_W-1:0]     rd_base,
  output logic [OFF_W-1:0]    rd_limit,
  output logic                rd_present,
  output logic [RIGHTS_W-1:0] rd_rights
);

  logic [PA_W-1:0]     base_a    [NSEG];
  logic [OFF_W-1:0]    limit_a   [NSEG];
  logic                present_a [NSEG];
  logic [RIGHTS_W-1:0] rights_a  [NSEG];

  for (genvar e = 0; e < NSEG; e++) begin : g_ent
    logic [PA_W-1:0]     base_q;
    logic [OFF_W-1:0]    limit_q;
    logic                present_q;
    logic [RIGHTS_W-1:0] rights_q;
    logic                hit;

    assign hit = wr_en && (wr_idx == SEG_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q    <= '0;
        limit_q   <= '0;
        present_q <= 1'b0;
        rights_q  <= '0;
      end else if (hit) begin
        base_q    <= wr_base;
        limit_q   <= wr_limit;
        present_q <= wr_present;
        rights_q  <= wr_rights;
      end
    end

    assign base_a[e]    = base_q;
    assign limit_a[e]   = limit_q;
    assign present_a[e] = present_q;
    assign rights_a[e]  = rights_q;
  end

  logic idx_ok;
  assign idx_ok = ({1'b0, rd_idx} < (SEG_W+1)'(NSEG));

  always_comb begin
    rd_base    = '0;
    rd_limit   = '0;
    rd_present = 1'b0;
    rd_rights  = '0;
    if (idx_ok) begin
      rd_base    = base_a[rd_idx];
      rd_limit   = limit_a[rd_idx];
      rd_present = present_a[rd_idx];
      rd_rights  = rights_a[rd_idx];
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int SEG_W = 4,
  parameter int CNT_W = 5
) (
  input  logic [SEG_W-1:0]    seg,
  input  logic [OFF_W-1:0]    off,
  input  logic [1:0]          acc,
  input  logic [CNT_W-1:0]    seg_cnt,
  input  logic [PA_W-1:0]     ent_base,
  input  logic [OFF_W-1:0]    ent_limit,
  input  logic                ent_present,
  input  logic [RIGHTS_W-1:0] ent_rights,
  output trap_code_e          code,
  output logic [PA_W-1:0]     paddr
);

  localparam int SUM_W = ((PA_W > OFF_W) ? PA_W : OFF_W) + 1;

  function automatic logic [PA_W-1:0] relocate(input logic [PA_W-1:0] b,
                                               input logic [OFF_W-1:0] o);
    logic [SUM_W-1:0] s;
    s = SUM_W'(b) + SUM_W'(o);
    return s[PA_W-1:0];
  endfunction

  function automatic logic seg_in_range(input logic [SEG_W-1:0] s,
                                        input logic [CNT_W-1:0] n);
    return (CNT_W'(s) < n);
  endfunction

  logic range_ok, present_ok, limit_ok, rights_ok;

  assign range_ok   = seg_in_range(seg, seg_cnt);
  assign present_ok = ent_present;
  assign limit_ok   = (off < ent_limit);
  assign rights_ok  = rights_allow(ent_rights, acc);

  always_comb begin
    if (!range_ok)        code = TC_RANGE;
    else if (!present_ok) code = TC_ABSENT;
    else if (!limit_ok)   code = TC_LIMIT;
    else if (!rights_ok)  code = TC_RIGHTS;
    else                  code = TC_NONE;
  end

  assign paddr = (code == TC_NONE) ? relocate(ent_base, off) : '0;

endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  trap_code_e      in_code,
  input  logic [PA_W-1:0] in_paddr,
  output logic            out_valid,
  output logic            out_trap,
  output logic [2:0]      out_code,
  output logic [PA_W-1:0] out_paddr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_trap  <= 1'b0;
      out_code  <= '0;
      out_paddr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_trap  <= (in_code != TC_NONE);
        out_code  <= in_code;
        out_paddr <= in_paddr;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1,
  parameter int CNT_W = $clog2(NSEG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [SEG_W-1:0] tbl_idx,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [OFF_W-1:0] tbl_limit,
  input  logic             tbl_present,
  input  logic [2:0]       tbl_rights,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic             rsp_trap,
  output logic [2:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_paddr
);

  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0]    cnt_q;
  logic [PA_W-1:0]     ent_base_rd;
  logic [OFF_W-1:0]    ent_limit_rd;
  logic                ent_present_rd;
  logic [RIGHTS_W-1:0] ent_rights_rd;
  trap_code_e          chk_code;
  logic [PA_W-1:0]     chk_paddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_val;
  end

  seg_table #(
    .NSEG(NSEG), .OFF_W(OFF_W), .PA_W(PA_W), .SEG_W(SEG_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_we),
    .wr_idx     (tbl_idx),
    .wr_base    (tbl_base),
    .wr_limit   (tbl_limit),
    .wr_present (tbl_present),
    .wr_rights  (tbl_rights),
    .rd_idx     (req_seg),
    .rd_base    (ent_base_rd),
    .rd_limit   (ent_limit_rd),
    .rd_present (ent_present_rd),
    .rd_rights  (ent_rights_rd)
  );

  seg_check #(
    .OFF_W(OFF_W), .PA_W(PA_W), .SEG_W(SEG_W), .CNT_W(CNT_W)
  ) u_check (
    .seg         (req_seg),
    .off         (req_off),
    .acc         (req_acc),
    .seg_cnt     (cnt_q),
    .ent_base    (ent_base_rd),
    .ent_limit   (ent_limit_rd),
    .ent_present (ent_present_rd),
    .ent_rights  (ent_rights_rd),
    .code        (chk_code),
    .paddr       (chk_paddr)
  );

  seg_resp_reg #(
    .PA_W(PA_W)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_code   (chk_code),
    .in_paddr  (chk_paddr),
    .out_valid (rsp_valid),
    .out_trap  (rsp_trap),
    .out_code  (rsp_code),
    .out_paddr (rsp_paddr)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int SEG_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SEG_W-1:0] req_seg,
  input logic             rsp_valid,
  input logic             rsp_trap,
  input logic [2:0]       rsp_code,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ent_present_rd
);

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  range_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (CNT_W'(req_seg) >= cnt_q)) |=> (rsp_code == 3'd1));

  // R3
  absent_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (CNT_W'(req_seg) < cnt_q) && !ent_present_rd)
      |=> (rsp_code == 3'd2));

  // R10
  trap_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap) |-> (rsp_paddr == '0));

  // R10
  trap_flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_trap == (rsp_code != 3'd0)));

  // R7
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code <= 3'd4));

endmodule

bind seg_xlate_unit seg_xlate_chk #(
  .OFF_W(OFF_W), .PA_W(PA_W), .SEG_W(SEG_W), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_seg        (req_seg),
  .rsp_valid      (rsp_valid),
  .rsp_trap       (rsp_trap),
  .rsp_code       (rsp_code),
  .rsp_paddr      (rsp_paddr),
  .cnt_q          (cnt_q),
  .ent_present_rd (ent_present_rd)
);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;

  localparam int NSEG  = 16;
  localparam int OFF_W = 16;
  localparam int PA_W  = 24;
  localparam int SEG_W = 4;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tbl_we = 1'b0;
  logic [SEG_W-1:0] tbl_idx = '0;
  logic [PA_W-1:0]  tbl_base = '0;
  logic [OFF_W-1:0] tbl_limit = '0;
  logic             tbl_present = 1'b0;
  logic [2:0]       tbl_rights = '0;
  logic             cnt_we = 1'b0;
  logic [CNT_W-1:0] cnt_val = '0;
  logic             req_valid = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_acc = '0;
  logic             rsp_valid;
  logic             rsp_trap;
  logic [2:0]       rsp_code;
  logic [PA_W-1:0]  rsp_paddr;

  always #2 clk = ~clk;  // 250 MHz

  seg_xlate_unit dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [2:0]      code;
    logic [PA_W-1:0] paddr;
    string           tag;
  } exp_t;
  exp_t sb_q[$];

  // Independent reference state
  logic [PA_W-1:0]  m_base    [NSEG];
  logic [OFF_W-1:0] m_limit   [NSEG];
  bit               m_present [NSEG];
  logic [2:0]       m_rights  [NSEG];
  int               m_cnt;

  function automatic exp_t predict(int s, int o, int a, string tag);
    exp_t e;
    bit allowed;
    e.tag = tag;
    e.paddr = '0;
    allowed = (a == 0) ? m_rights[s][0] :
              (a == 1) ? m_rights[s][1] :
              (a == 2) ? m_rights[s][2] : 1'b0;
    if (s >= m_cnt)                e.code = 3'd1;
    else if (!m_present[s])        e.code = 3'd2;
    else if (o >= int'(m_limit[s])) e.code = 3'd3;
    else if (!allowed)             e.code = 3'd4;
    else begin
      e.code  = 3'd0;
      e.paddr = PA_W'((longint'(m_base[s]) + longint'(o)) % (longint'(1) << PA_W));
    end
    return e;
  endfunction

  task automatic fail_line(string tag, string what, longint act, longint expv);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
  endtask

  // Driver: one call is one clock cycle.
  task automatic cycle(bit wr, int widx, int wbase, int wlim, bit wpres, int wrt,
                       bit cw, int cv,
                       bit lk, int s, int o, int a, string tag);
    @(negedge clk);
    tbl_we      = wr;
    tbl_idx     = SEG_W'(widx);
    tbl_base    = PA_W'(wbase);
    tbl_limit   = OFF_W'(wlim);
    tbl_present = wpres;
    tbl_rights  = 3'(wrt);
    cnt_we      = cw;
    cnt_val     = CNT_W'(cv);
    req_valid   = lk;
    req_seg     = SEG_W'(s);
    req_off     = OFF_W'(o);
    req_acc     = 2'(a);
    if (lk) sb_q.push_back(predict(s, o, a, tag));
    if (wr) begin
      m_base[widx] = PA_W'(wbase); m_limit[widx] = OFF_W'(wlim);
      m_present[widx] = wpres;     m_rights[widx] = 3'(wrt);
    end
    if (cw) m_cnt = cv;
  endtask

  task automatic wr_ent(int i, int b, int l, bit p, int r);
    cycle(1, i, b, l, p, r, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic look(int s, int o, int a, string tag);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, s, o, a, tag);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // Monitor: samples one time unit after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rsp_valid) begin
        if (sb_q.size() == 0) begin
          n_cmp++;
          fail_line("R1", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          n_cmp++;
          if (rsp_code !== e.code || rsp_paddr !== e.paddr ||
              rsp_trap !== (e.code != 0)) begin
            n_bad++;
            $display("FAIL %s code/paddr/trap actual=%0d/%0h/%0b expected=%0d/%0h/%0b",
                     e.tag, rsp_code, rsp_paddr, rsp_trap,
                     e.code, e.paddr, (e.code != 0));
          end
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_present[i] = 0; m_rights[i] = '0;
    end
    m_cnt = 0;
    repeat (3) @(negedge clk);
    // R9: outputs quiet during and right after reset
    n_cmp++;
    if (rsp_valid !== 1'b0) fail_line("R9", "rsp_valid in reset", rsp_valid, 0);
    n_cmp++;
    if (rsp_trap !== 1'b0 || rsp_paddr !== '0)
      fail_line("R9", "rsp_trap/paddr in reset", rsp_paddr, 0);
    rst_n = 1'b1;
    idle();
    // R9: empty table, count zero -> range trap
    look(0, 0, 0, "R9");
    look(15, 3, 2, "R9");
    idle();

    // Build table: count 4
    cycle(0, 0, 0, 0, 0, 0, 1, 4, 0, 0, 0, 0, "");
    wr_ent(0, 'h001000, 'h0100, 1, 3'b111);
    wr_ent(1, 'hFFFF00, 'hFFFF, 1, 3'b001);
    wr_ent(2, 'h0A0000, 'h0001, 0, 3'b000);
    wr_ent(3, 'h200000, 'h0010, 1, 3'b100);
    wr_ent(4, 'h400000, 'h1000, 1, 3'b111);

    // R6: legal lookups, back to back, incl. wrap-around
    look(0, 'h55, 0, "R6");
    look(0, 'hFF, 1, "R6");
    look(1, 'h200, 0, "R6");
    look(3, 'hF, 2, "R6");
    idle();
    // R4: offset at and beyond limit
    look(0, 'h100, 0, "R4");
    look(3, 'h10, 2, "R4");
    look(1, 'hFFFF, 0, "R4");
    // R5: denied access kinds
    look(1, 4, 1, "R5");
    look(3, 4, 0, "R5");
    look(0, 4, 3, "R5");
    look(1, 4, 2, "R5");
    // R3: not-present descriptor
    look(2, 0, 0, "R3");
    // R2: beyond count (descriptor 4 present but unused)
    look(4, 0, 0, "R2");
    look(15, 0, 0, "R2");
    idle();
    // R7: multiple failures at once
    look(2, 'h9000, 1, "R7");
    look(1, 'hFFFF, 1, "R7");
    look(5, 'hFFFF, 3, "R7");
    look(0, 'h200, 3, "R7");
    idle();
    // R8: descriptor write and lookup in one cycle, then again
    cycle(1, 2, 'h300000, 'h40, 1, 3'b001, 0, 0, 1, 2, 4, 0, "R8");
    look(2, 4, 0, "R8");
    // R8: count write and lookup in one cycle
    cycle(0, 0, 0, 0, 0, 0, 1, 5, 1, 4, 8, 1, "R8");
    look(4, 8, 1, "R8");
    idle();
    idle();
    idle();
    // R1: every request answered, no extras
    n_cmp++;
    if (sb_q.size() != 0) fail_line("R1", "missing responses", sb_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule